// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block turns the interrupt sources of a 16550-style serial port into one identification byte and one interrupt request line. It holds the four-bit interrupt enable register, the transmit-holding-empty (THRE) and transmitter-empty (TEMT) status bits, and the flag that records a pending "holding register empty" interrupt. The receive FIFO, the character timer, the line status error logic and the modem status logic stay outside. Their current state arrives on input ports.

The host side supplies three strobes: one for a write of the enable register, one for a write of the transmit holding register, and one for a read of the identification register. The identification byte is decoded combinationally from registered state and the source inputs. A read returns the value present in the strobe cycle. Any flag the read clears changes on the following clock edge. The transmit path reports two events. One is a pulse when the holding path has been emptied. The other is a pulse when the shifter has gone idle.

Top module: `uart_irq_prio`

## Requirements
- R1: The low nibble of the identification byte comes from the first active source in this fixed order. Line status error: enable bit 2 set and any of the four error inputs set, code 0x6. Character timeout: enable bit 0, code 0xC. Received data: enable bit 0, code 0x4. Holding-empty pending: enable bit 1, code 0x2. Modem status change: enable bit 3 with any delta bit set, code 0x0. A source whose enable bit is clear is skipped.
- R2: When no source is active the low nibble is 0x1. The interrupt line is high exactly when bit 0 of the identification byte is 0.
- R3: Bits 7:6 of the identification byte are 11 while the FIFO-enable input is 1 and 00 otherwise, whatever the code. Bits 5:4 are always 0.
- R4: A read strobe in a cycle where the code is 0x2 clears the holding-empty pending flag from the next cycle on. A read while another code is shown leaves the flag unchanged.
- R5: A write of the transmit holding register clears the pending flag, THRE and TEMT from the next cycle on.
- R6: A holding-path-empty pulse sets THRE and the pending flag. A shifter-idle pulse sets TEMT. Both take effect in the next cycle.
- R7: An enable write that changes bit 1 sets the pending flag when the new bit is 1 and THRE is 1, and clears it in every other case. This includes re-arming a flag that an earlier read cleared. An enable write that leaves bit 1 unchanged does not touch the flag.
- R8: The received-data source requires data-ready. With the FIFO disabled, data-ready alone is enough. With the FIFO enabled, the receive count must also be at or above the trigger level.
- R9: After reset the enable register is 0, the pending flag is 0, THRE and TEMT are 1, and the interrupt line is low.
- R10: An enable write stores the written value, and it is readable on the enable output from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ien_wr | input | 1 | Host write strobe for the enable register |
| ien_wdata | input | 4 | Enable value to write (bit 0 rx data/timeout, 1 tx empty, 2 line status, 3 modem status) |
| thr_wr | input | 1 | Host write strobe for the transmit holding register |
| iid_rd | input | 1 | Host read strobe for the identification register |
| fifo_on | input | 1 | FIFO mode enabled |
| lsr_err | input | 4 | Line error bits: overrun, parity, framing, break |
| rx_ready | input | 1 | Receive data ready |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| rx_timeout | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem status delta bits |
| tx_hold_empty | input | 1 | Pulse: transmit holding path became empty |
| tx_shift_empty | input | 1 | Pulse: transmit shifter became idle |
| ien | output | 4 | Current enable register |
| iid | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request |
| thre | output | 1 | Transmit holding empty status |
| temt | output | 1 | Transmitter empty status |

## Verification
The bench builds the block with its default 16-entry FIFO depth, which makes the count and trigger ports five bits wide. At that width, trigger levels around 4 can be placed just below and just at the count to test the threshold edge of the received-data source. The bench removes sources one at a time from the top of the priority order so that every code level is reached. It exercises the pending flag along its paths: clear by read, survival of a read that shows another code, clear by write, set by a transmit event, and re-arm through an enable-bit toggle with THRE both high and low.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int IEN_W = 4;

    // Enable register bit positions
    localparam int IEN_RX  = 0;
    localparam int IEN_TX  = 1;
    localparam int IEN_LS  = 2;
    localparam int IEN_MS  = 3;

    // Identification codes (low nibble)
    localparam logic [3:0] CODE_NONE    = 4'h1;
    localparam logic [3:0] CODE_LINE    = 4'h6;
    localparam logic [3:0] CODE_TIMEOUT = 4'hC;
    localparam logic [3:0] CODE_RXDATA  = 4'h4;
    localparam logic [3:0] CODE_TXEMPTY = 4'h2;
    localparam logic [3:0] CODE_MODEM   = 4'h0;

    typedef struct packed {
        logic [IEN_W-1:0] ien;
        logic             pend;
        logic             thre;
        logic             temt;
    } irq_state_t;

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_wr,
    input  logic [IEN_W-1:0] ien_wdata,
    input  logic             thr_wr,
    input  logic             iid_rd,
    input  logic             code_is_tx,
    input  logic             tx_hold_empty,
    input  logic             tx_shift_empty,
    output logic [IEN_W-1:0] ien_q,
    output logic             pend_q,
    output logic             thre_q,
    output logic             temt_q
);

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tx_hold_empty) begin
            st_d.thre = 1'b1;
            st_d.pend = 1'b1;
        end
        if (tx_shift_empty) begin
            st_d.temt = 1'b1;
        end
        if (iid_rd && code_is_tx) begin
            st_d.pend = 1'b0;
        end
        if (ien_wr) begin
            st_d.ien = ien_wdata;
            if (ien_wdata[IEN_TX] != st_q.ien[IEN_TX]) begin
                st_d.pend = ien_wdata[IEN_TX] & st_q.thre;
            end
        end
        if (thr_wr) begin
            st_d.pend = 1'b0;
            st_d.thre = 1'b0;
            st_d.temt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ien: '0, pend: 1'b0, thre: 1'b1, temt: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign ien_q  = st_q.ien;
    assign pend_q = st_q.pend;
    assign thre_q = st_q.thre;
    assign temt_q = st_q.temt;

    AST_THR_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> (!pend_q && !thre_q && !temt_q)); // R5

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (iid_rd && code_is_tx && !ien_wr && !tx_hold_empty) |=> !pend_q); // R4

    AST_REARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_wr && ien_wdata[IEN_TX] && !ien_q[IEN_TX] && thre_q && !thr_wr) |=> pend_q); // R7

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_wr && !ien_wdata[IEN_TX] && ien_q[IEN_TX]) |=> !pend_q); // R7

    AST_HOLD_EMPTY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hold_empty && !thr_wr) |=> thre_q); // R6

    AST_IEN_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        ien_wr |=> (ien_q == $past(ien_wdata))); // R10

endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IEN_W-1:0] ien_q,
    input  logic [3:0]       lsr_err,
    input  logic             rx_timeout,
    input  logic             rx_ready,
    input  logic             fifo_on,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             pend_q,
    input  logic [3:0]       msr_delta,
    output logic [3:0]       code
);

    logic line_act, tmo_act, rxd_act, tx_act, ms_act;
    logic rx_level_ok;

    assign rx_level_ok = !fifo_on || (rx_count >= rx_trig);

    assign line_act = ien_q[IEN_LS] && (|lsr_err);
    assign tmo_act  = ien_q[IEN_RX] && rx_timeout;
    assign rxd_act  = ien_q[IEN_RX] && rx_ready && rx_level_ok;
    assign tx_act   = ien_q[IEN_TX] && pend_q;
    assign ms_act   = ien_q[IEN_MS] && (|msr_delta);

    always_comb begin
        if (line_act)      code = CODE_LINE;
        else if (tmo_act)  code = CODE_TIMEOUT;
        else if (rxd_act)  code = CODE_RXDATA;
        else if (tx_act)   code = CODE_TXEMPTY;
        else if (ms_act)   code = CODE_MODEM;
        else               code = CODE_NONE;
    end

    AST_LINE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q[IEN_LS] && (|lsr_err)) |-> (code == CODE_LINE)); // R1

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> (code == CODE_NONE)); // R2

    AST_FIFO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_on && (rx_count < rx_trig) && !rx_timeout && !(ien_q[IEN_LS] && (|lsr_err)))
        |-> (code != CODE_RXDATA)); // R8

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_wr,
    input  logic [3:0]       ien_wdata,
    input  logic             thr_wr,
    input  logic             iid_rd,
    input  logic             fifo_on,
    input  logic [3:0]       lsr_err,
    input  logic             rx_ready,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             rx_timeout,
    input  logic [3:0]       msr_delta,
    input  logic             tx_hold_empty,
    input  logic             tx_shift_empty,
    output logic [3:0]       ien,
    output logic [7:0]       iid,
    output logic             irq,
    output logic             thre,
    output logic             temt
);

    logic [3:0] code;
    logic       pend;

    uart_irq_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .ien_wr         (ien_wr),
        .ien_wdata      (ien_wdata),
        .thr_wr         (thr_wr),
        .iid_rd         (iid_rd),
        .code_is_tx     (code == CODE_TXEMPTY),
        .tx_hold_empty  (tx_hold_empty),
        .tx_shift_empty (tx_shift_empty),
        .ien_q          (ien),
        .pend_q         (pend),
        .thre_q         (thre),
        .temt_q         (temt)
    );

    uart_irq_arb #(.CNT_W(CNT_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .ien_q      (ien),
        .lsr_err    (lsr_err),
        .rx_timeout (rx_timeout),
        .rx_ready   (rx_ready),
        .fifo_on    (fifo_on),
        .rx_count   (rx_count),
        .rx_trig    (rx_trig),
        .pend_q     (pend),
        .msr_delta  (msr_delta),
        .code       (code)
    );

    assign iid = {{2{fifo_on}}, 2'b00, code};
    assign irq = ~code[0];

    AST_MODE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (iid[7:4] == (fifo_on ? 4'hC : 4'h0))); // R3

    AST_IRQ_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iid[3:0] != CODE_NONE)); // R2

endmodule

// File: tb/uart_irq_prio_tb.sv
module uart_irq_prio_tb;

    localparam int CLK_PERIOD = 10;
    localparam int FIFO_DEPTH = 16;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             ien_wr, thr_wr, iid_rd, fifo_on, rx_ready, rx_timeout;
    logic [3:0]       ien_wdata, lsr_err, msr_delta;
    logic [CNT_W-1:0] rx_count, rx_trig;
    logic             tx_hold_empty, tx_shift_empty;
    logic [3:0]       ien;
    logic [7:0]       iid;
    logic             irq, thre, temt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_prio #(.FIFO_DEPTH(FIFO_DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
        .thr_wr(thr_wr), .iid_rd(iid_rd), .fifo_on(fifo_on), .lsr_err(lsr_err),
        .rx_ready(rx_ready), .rx_count(rx_count), .rx_trig(rx_trig),
        .rx_timeout(rx_timeout), .msr_delta(msr_delta),
        .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty),
        .ien(ien), .iid(iid), .irq(irq), .thre(thre), .temt(temt)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // advance to next falling edge and settle
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic write_ien(input logic [3:0] v);
        ien_wr = 1'b1; ien_wdata = v;
        step();
        ien_wr = 1'b0;
    endtask

    task automatic pulse_thr();
        thr_wr = 1'b1; step(); thr_wr = 1'b0;
    endtask

    task automatic clear_sources();
        lsr_err = '0; rx_ready = 0; rx_timeout = 0; msr_delta = '0;
        fifo_on = 0; rx_count = '0; rx_trig = 1;
    endtask

    task automatic t_reset();
        chk("R9 ien", {4'h0, ien}, 8'h00);
        chk("R9 iid", iid, 8'h01);
        chk("R9 irq", {7'h0, irq}, 8'h00);
        chk("R9 thre/temt", {6'h0, thre, temt}, 8'h03);
    endtask

    task automatic t_priority();
        clear_sources();
        lsr_err = 4'b0100; rx_timeout = 1; rx_ready = 1; msr_delta = 4'b0010;
        write_ien(4'hF);
        chk("R10 ien stored", {4'h0, ien}, 8'h0F);
        chk("R1 line first", iid, 8'h06);
        lsr_err = '0; #1;
        chk("R1 timeout", iid, 8'h0C);
        rx_timeout = 0; #1;
        chk("R1 rx data", iid, 8'h04);
        rx_ready = 0; #1;
        chk("R1 tx empty", iid, 8'h02);
        iid_rd = 1; #1;
        chk("R4 read value in strobe cycle", iid, 8'h02);
        step(); iid_rd = 0; #1;
        chk("R4 read cleared, modem next", iid, 8'h00);
        chk("R2 irq with modem", {7'h0, irq}, 8'h01);
        msr_delta = '0; #1;
        chk("R2 nothing pending", iid, 8'h01);
        chk("R2 irq low", {7'h0, irq}, 8'h00);
    endtask

    task automatic t_masking();
        clear_sources();
        write_ien(4'h0);
        lsr_err = 4'b1111; rx_timeout = 1; rx_ready = 1; msr_delta = 4'b1000; #1;
        chk("R1 all masked", iid, 8'h01);
        write_ien(4'h8);
        chk("R1 only modem enabled", iid, 8'h00);
        write_ien(4'h1);
        chk("R1 timeout without line enable", iid, 8'h0C);
        clear_sources();
        write_ien(4'h0);
    endtask

    task automatic t_fifo();
        clear_sources();
        fifo_on = 1; #1;
        chk("R3 fifo bits idle", iid, 8'hC1);
        write_ien(4'h1);
        rx_ready = 1; rx_trig = 4; rx_count = 3; #1;
        chk("R8 below trigger", iid, 8'hC1);
        rx_count = 4; #1;
        chk("R8 at trigger", iid, 8'hC4);
        chk("R3 fifo bits with code", {6'h0, iid[7:6]}, 8'h03);
        fifo_on = 0; rx_count = 0; #1;
        chk("R8 fifo off ready only", iid, 8'h04);
        clear_sources();
        write_ien(4'h0);
    endtask

    task automatic t_thr_path();
        clear_sources();
        write_ien(4'h2);
        chk("R7 arm with thre", iid, 8'h02);
        pulse_thr();
        chk("R5 thr write clears", iid, 8'h01);
        chk("R5 thre/temt low", {6'h0, thre, temt}, 8'h00);
        write_ien(4'h0);
        write_ien(4'h2);
        chk("R7 no arm while thre low", iid, 8'h01);
        tx_hold_empty = 1; step(); tx_hold_empty = 0;
        chk("R6 hold empty sets", iid, 8'h02);
        chk("R6 thre set temt not", {6'h0, thre, temt}, 8'h02);
        tx_shift_empty = 1; step(); tx_shift_empty = 0;
        chk("R6 temt set", {6'h0, thre, temt}, 8'h03);
    endtask

    task automatic t_read_other();
        clear_sources();
        write_ien(4'h3);
        chk("R7 bit1 unchanged keeps pend", iid, 8'h02);
        rx_ready = 1; #1;
        chk("R1 rx over tx", iid, 8'h04);
        iid_rd = 1; step(); iid_rd = 0;
        rx_ready = 0; #1;
        chk("R4 other-code read keeps pend", iid, 8'h02);
        iid_rd = 1; step(); iid_rd = 0;
        chk("R4 cleared", iid, 8'h01);
        write_ien(4'h2);
        chk("R7 same bit1 no rearm", iid, 8'h01);
        write_ien(4'h0);
        write_ien(4'h2);
        chk("R7 toggle rearms", iid, 8'h02);
        write_ien(4'h0);
        write_ien(4'h2);
        chk("R7 rearm again", iid, 8'h02);
        write_ien(4'h0);
        chk("R7 disable hides", iid, 8'h01);
    endtask

    initial begin
        rst_n = 0; ien_wr = 0; ien_wdata = '0; thr_wr = 0; iid_rd = 0;
        tx_hold_empty = 0; tx_shift_empty = 0;
        clear_sources();
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset();
        t_priority();
        t_masking();
        t_fifo();
        t_thr_path();
        t_read_other();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule